// File: doc/BRIEF.md
# Transmit Auto-Release Completion Controller

This block decides what happens when the MAC reports the outcome of each packet in a queued transmit sequence. The packet buffer is organised in pages, and every packet is named by a packet number. The controller turns each reported outcome into one of two actions. It either requests that the packet's pages be freed, or it places the packet number in a small completion FIFO for the CPU to read. It also raises the transmit interrupt, raises the transmit-empty interrupt, and drives the transmitter enable.

With auto-release switched on, a packet that is sent without error has its pages freed at once. No completion entry is written for it and no per-packet interrupt is raised, so a whole sequence produces a single transmit-empty interrupt when its last packet goes out. A fatal error behaves differently. It stops the sequence by dropping the transmitter enable, keeps the failed packet's pages, records the failed packet number and raises the transmit interrupt. The CPU can then correct the fault and set the enable again, which resumes the queue at the failed packet. With auto-release switched off, every outcome is queued for the CPU and no pages are freed by the block.

Top module: `tx_autorel_ctrl`

## Requirements
- R1: When auto-release is on and an accepted result reports success, `rel_req` is high for exactly the following cycle and `rel_pnum` carries that result's packet number. No completion entry is written for that packet.
- R2: When auto-release is off, every accepted result (success or fatal) writes its packet number into the completion FIFO, and `rel_req` stays low.
- R3: An accepted fatal result (`tx_ok`=0) writes its packet number into the completion FIFO and loads it into `fail_pnum`. In the next cycle it also drives `tx_ena` low and sets `tx_int`. No release is requested for it.
- R4: An accepted successful result with `queue_empty` high sets `tx_empty_int` in the next cycle, whatever the auto-release setting. A successful result with `queue_empty` low does not set it.
- R5: With auto-release on, only fatal results set `tx_int`. With auto-release off, every accepted result sets `tx_int`.
- R6: `tx_go` is high only while `tx_ena` is high and `queue_empty` is low. A `tx_done` that arrives while `tx_ena` is low is ignored: it produces no release, no FIFO entry and no interrupt.
- R7: A `tx_en_set` pulse drives `tx_ena` high in the next cycle. If a fatal result is accepted in the same cycle, the clear wins and `tx_ena` stays low.
- R8: The completion FIFO holds 4 entries, and `cf_head` shows the oldest entry, in arrival order. A write while the FIFO is full and not being popped is dropped and sets `cf_ovf`, which stays high until reset.
- R9: `int_ack[0]` clears `tx_int` and `int_ack[1]` clears `tx_empty_int`. A new set in the same cycle wins over the clear.
- R10: After reset, `tx_ena`, `tx_int`, `tx_empty_int`, `rel_req` and `cf_ovf` are low and `cf_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| auto_rel_en | input | 1 | Auto-release mode enable |
| tx_en_set | input | 1 | Pulse that sets the transmitter enable |
| tx_done | input | 1 | Transmit result strobe |
| tx_ok | input | 1 | Result kind: 1 success, 0 fatal error |
| tx_pnum | input | PKT_W | Packet number of the result |
| queue_empty | input | 1 | No further packets are queued after the current one |
| int_ack | input | 2 | Interrupt clear: bit 0 clears tx_int, bit 1 clears tx_empty_int |
| cf_pop | input | 1 | Remove the head entry of the completion FIFO |
| tx_ena | output | 1 | Transmitter enable |
| tx_go | output | 1 | Permission to start the next queued packet |
| rel_req | output | 1 | One-cycle page release request |
| rel_pnum | output | PKT_W | Packet number to release |
| tx_int | output | 1 | Transmit interrupt flag |
| tx_empty_int | output | 1 | Transmit-empty interrupt flag |
| fail_pnum | output | PKT_W | Number of the most recent failed packet |
| cf_empty | output | 1 | Completion FIFO is empty |
| cf_head | output | PKT_W | Oldest completion FIFO entry |
| cf_ovf | output | 1 | Sticky completion FIFO overflow flag |

## Verification
Some rules can be checked on every cycle, and the assertions cover those. They check that each release pulse matches an accepted success in auto-release mode and carries its packet number. They check that an accepted fatal result drops the enable and raises `tx_int`, that `tx_go` never rises while the enable is low, that results arriving while the enable is low have no effect, and that the overflow flag stays set once raised. Other behaviour depends on a whole sequence of results, and only the bench scenarios show it. These are the FIFO order and the drop of the fifth entry, a single transmit-empty interrupt for the end of a sequence, restart after a fatal error, and the set-over-clear priorities.

// File: rtl/tx_autorel_pkg.sv
package tx_autorel_pkg;

  // Per-result action set produced by the decoder
  typedef struct packed {
    logic rel;        // request page release
    logic push;       // write packet number into completion FIFO
    logic set_txint;  // raise transmit interrupt
    logic set_eint;   // raise transmit-empty interrupt
    logic kill;       // fatal: stop sequence, latch failed number
  } txc_act_t;

  localparam int unsigned IRQ_BITS = 2;
  localparam int unsigned ACK_TXINT = 0;
  localparam int unsigned ACK_EMPTY = 1;

endpackage

// File: rtl/txc_decode.sv
module txc_decode
  import tx_autorel_pkg::*;
(
  input  logic     auto_rel_en,
  input  logic     tx_ena,
  input  logic     tx_done,
  input  logic     tx_ok,
  input  logic     queue_empty,
  output txc_act_t act
);

  logic accept;
  logic keep_record;

  always_comb begin
    accept        = tx_done & tx_ena;
    keep_record   = ~tx_ok | ~auto_rel_en;
    act.rel       = accept & tx_ok & auto_rel_en;
    act.push      = accept & keep_record;
    act.set_txint = accept & keep_record;
    act.set_eint  = accept & tx_ok & queue_empty;
    act.kill      = accept & ~tx_ok;
  end

endmodule

// File: rtl/txc_cfifo.sv
module txc_cfifo #(
  parameter int unsigned W     = 6,
  parameter int unsigned DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_core_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic         empty,
  output logic [W-1:0] head,
  output logic         ovf
);

  localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW    = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_nxt;
  logic [AW-1:0] rd_ptr, rd_ptr_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          ovf_nxt;
  logic          full;
  logic          do_pop;
  logic          do_push;

  always_comb begin
    full    = (cnt == FULL);
    empty   = (cnt == '0);
    do_pop  = pop & ~empty;
    do_push = push & (~full | do_pop);
    ovf_nxt = ovf | (push & full & ~do_pop);

    wr_ptr_nxt = wr_ptr;
    if (do_push) wr_ptr_nxt = (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
    rd_ptr_nxt = rd_ptr;
    if (do_pop) rd_ptr_nxt = (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;

    cnt_nxt = cnt;
    if (do_push && !do_pop) cnt_nxt = cnt + 1'b1;
    else if (do_pop && !do_push) cnt_nxt = cnt - 1'b1;

    head = mem[rd_ptr];
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      ovf    <= 1'b0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      cnt    <= cnt_nxt;
      ovf    <= ovf_nxt;
    end
  end

  // Storage has no reset; entries are only read once written
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_ptr == AW'(i)) mem[i] <= din;
    end
  end

endmodule

// File: rtl/txc_seqctl.sv
module txc_seqctl
  import tx_autorel_pkg::*;
#(
  parameter int unsigned W = 6
) (
  input  logic                clk,
  input  logic                rst_core_n,
  input  txc_act_t            act,
  input  logic                tx_en_set,
  input  logic [IRQ_BITS-1:0] int_ack,
  input  logic [W-1:0]        tx_pnum,
  output logic                tx_ena,
  output logic                tx_int,
  output logic                tx_empty_int,
  output logic                rel_req,
  output logic [W-1:0]        rel_pnum,
  output logic [W-1:0]        fail_pnum
);

  logic ena_nxt;
  logic txint_nxt;
  logic eint_nxt;

  always_comb begin
    ena_nxt = tx_ena;
    if (act.kill)       ena_nxt = 1'b0;
    else if (tx_en_set) ena_nxt = 1'b1;
    txint_nxt = act.set_txint | (tx_int & ~int_ack[ACK_TXINT]);
    eint_nxt  = act.set_eint  | (tx_empty_int & ~int_ack[ACK_EMPTY]);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tx_ena       <= 1'b0;
      tx_int       <= 1'b0;
      tx_empty_int <= 1'b0;
      rel_req      <= 1'b0;
    end else begin
      tx_ena       <= ena_nxt;
      tx_int       <= txint_nxt;
      tx_empty_int <= eint_nxt;
      rel_req      <= act.rel;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      rel_pnum  <= '0;
      fail_pnum <= '0;
    end else begin
      if (act.rel)  rel_pnum  <= tx_pnum;
      if (act.kill) fail_pnum <= tx_pnum;
    end
  end

endmodule

// File: rtl/tx_autorel_ctrl.sv
module tx_autorel_ctrl
  import tx_autorel_pkg::*;
#(
  parameter int unsigned PKT_W    = 6,
  parameter int unsigned CF_DEPTH = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                auto_rel_en,
  input  logic                tx_en_set,
  input  logic                tx_done,
  input  logic                tx_ok,
  input  logic [PKT_W-1:0]    tx_pnum,
  input  logic                queue_empty,
  input  logic [IRQ_BITS-1:0] int_ack,
  input  logic                cf_pop,
  output logic                tx_ena,
  output logic                tx_go,
  output logic                rel_req,
  output logic [PKT_W-1:0]    rel_pnum,
  output logic                tx_int,
  output logic                tx_empty_int,
  output logic [PKT_W-1:0]    fail_pnum,
  output logic                cf_empty,
  output logic [PKT_W-1:0]    cf_head,
  output logic                cf_ovf
);

  logic [1:0] rst_sync;
  logic       rst_core_n;
  txc_act_t   act;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  txc_decode u_dec (
    .auto_rel_en (auto_rel_en),
    .tx_ena      (tx_ena),
    .tx_done     (tx_done),
    .tx_ok       (tx_ok),
    .queue_empty (queue_empty),
    .act         (act)
  );

  txc_seqctl #(.W(PKT_W)) u_seq (
    .clk          (clk),
    .rst_core_n   (rst_core_n),
    .act          (act),
    .tx_en_set    (tx_en_set),
    .int_ack      (int_ack),
    .tx_pnum      (tx_pnum),
    .tx_ena       (tx_ena),
    .tx_int       (tx_int),
    .tx_empty_int (tx_empty_int),
    .rel_req      (rel_req),
    .rel_pnum     (rel_pnum),
    .fail_pnum    (fail_pnum)
  );

  txc_cfifo #(.W(PKT_W), .DEPTH(CF_DEPTH)) u_cf (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .push       (act.push),
    .din        (tx_pnum),
    .pop        (cf_pop),
    .empty      (cf_empty),
    .head       (cf_head),
    .ovf        (cf_ovf)
  );

  assign tx_go = tx_ena & ~queue_empty;

endmodule

// File: rtl/tx_autorel_ctrl_chk.sv
module tx_autorel_ctrl_chk #(
  parameter int unsigned PKT_W = 6
) (
  input logic             clk,
  input logic             rst_core_n,
  input logic             auto_rel_en,
  input logic             tx_done,
  input logic             tx_ok,
  input logic [PKT_W-1:0] tx_pnum,
  input logic             tx_ena,
  input logic             tx_go,
  input logic             rel_req,
  input logic [PKT_W-1:0] rel_pnum,
  input logic             tx_int,
  input logic             cf_ovf,
  input logic             cf_push
);

  // R1: each release pulse follows an accepted auto-mode success and carries its number
  assert_rel_source_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    rel_req |-> ($past(tx_done && tx_ok && auto_rel_en && tx_ena) && rel_pnum == $past(tx_pnum)));

  // R1: an auto-mode success never reaches the completion FIFO
  assert_no_record_R1: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_done && tx_ok && auto_rel_en) |-> !cf_push);

  // R3: an accepted fatal result stops the transmitter and raises tx_int
  assert_fatal_stop_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_done && !tx_ok && tx_ena) |=> (!tx_ena && tx_int));

  // R6: no start permission while the enable is low
  assert_no_go_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    !tx_ena |-> !tx_go);

  // R6: a result while the enable is low has no effect
  assert_ignored_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (tx_done && !tx_ena) |=> !rel_req);

  // R8: overflow flag is sticky
  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_core_n)
    cf_ovf |=> cf_ovf);

endmodule

bind tx_autorel_ctrl tx_autorel_ctrl_chk #(.PKT_W(PKT_W)) u_chk (
  .clk         (clk),
  .rst_core_n  (rst_core_n),
  .auto_rel_en (auto_rel_en),
  .tx_done     (tx_done),
  .tx_ok       (tx_ok),
  .tx_pnum     (tx_pnum),
  .tx_ena      (tx_ena),
  .tx_go       (tx_go),
  .rel_req     (rel_req),
  .rel_pnum    (rel_pnum),
  .tx_int      (tx_int),
  .cf_ovf      (cf_ovf),
  .cf_push     (act.push)
);

// File: tb/tx_autorel_ctrl_test.sv
`timescale 1ns/1ps
module tx_autorel_ctrl_test;

  localparam int PW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          auto_rel_en = 1'b0;
  logic          tx_en_set = 1'b0;
  logic          tx_done = 1'b0;
  logic          tx_ok = 1'b0;
  logic [PW-1:0] tx_pnum = '0;
  logic          queue_empty = 1'b1;
  logic [1:0]    int_ack = 2'b00;
  logic          cf_pop = 1'b0;
  logic          tx_ena, tx_go, rel_req, tx_int, tx_empty_int;
  logic          cf_empty, cf_ovf;
  logic [PW-1:0] rel_pnum, fail_pnum, cf_head;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  tx_autorel_ctrl #(.PKT_W(PW), .CF_DEPTH(4)) uut (
    .clk(clk), .rst_n(rst_n), .auto_rel_en(auto_rel_en), .tx_en_set(tx_en_set),
    .tx_done(tx_done), .tx_ok(tx_ok), .tx_pnum(tx_pnum), .queue_empty(queue_empty),
    .int_ack(int_ack), .cf_pop(cf_pop), .tx_ena(tx_ena), .tx_go(tx_go),
    .rel_req(rel_req), .rel_pnum(rel_pnum), .tx_int(tx_int),
    .tx_empty_int(tx_empty_int), .fail_pnum(fail_pnum), .cf_empty(cf_empty),
    .cf_head(cf_head), .cf_ovf(cf_ovf)
  );

  // Row: auto, ok, qempty, pnum[6], exp rel, push, txint, eint, ena
  localparam int NROW = 6;
  localparam logic [13:0] ROWS [NROW] = '{
    {1'b1, 1'b1, 1'b0, 6'd5,  1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 1'b1, 6'd6,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    {1'b1, 1'b0, 1'b0, 6'd7,  1'b0, 1'b1, 1'b1, 1'b0, 1'b0},
    {1'b0, 1'b1, 1'b0, 6'd8,  1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
    {1'b0, 1'b1, 1'b1, 6'd9,  1'b0, 1'b1, 1'b1, 1'b1, 1'b1},
    {1'b0, 1'b0, 1'b1, 6'd10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic enable_tx();
    @(negedge clk); tx_en_set = 1'b1; int_ack = 2'b11;
    @(negedge clk); tx_en_set = 1'b0; int_ack = 2'b00;
  endtask

  task automatic result(input logic a, input logic ok, input logic qe, input int pn);
    @(negedge clk);
    auto_rel_en = a; tx_ok = ok; queue_empty = qe; tx_pnum = PW'(pn); tx_done = 1'b1;
    @(negedge clk);
    tx_done = 1'b0;
  endtask

  task automatic pop_one();
    cf_pop = 1'b1;
    @(negedge clk);
    cf_pop = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    check("R10 tx_ena", tx_ena, 0);
    check("R10 tx_int", tx_int, 0);
    check("R10 tx_empty_int", tx_empty_int, 0);
    check("R10 rel_req", rel_req, 0);
    check("R10 cf_ovf", cf_ovf, 0);
    check("R10 cf_empty", cf_empty, 1);

    // R6: result while enable low is ignored
    result(1'b1, 1'b1, 1'b1, 3);
    check("R6 ignored rel_req", rel_req, 0);
    check("R6 ignored cf_empty", cf_empty, 1);
    check("R6 ignored tx_empty_int", tx_empty_int, 0);
    queue_empty = 1'b0;
    #1 check("R6 tx_go with enable low", tx_go, 0);

    // Vector table walk (R1 R2 R3 R4 R5)
    for (int i = 0; i < NROW; i++) begin
      logic [13:0] r;
      r = ROWS[i];
      enable_tx();
      result(r[13], r[12], r[11], int'(r[10:5]));
      check($sformatf("R1 row%0d rel_req", i), rel_req, r[4]);
      if (r[4]) check($sformatf("R1 row%0d rel_pnum", i), rel_pnum, r[10:5]);
      check($sformatf("R5 row%0d tx_int", i), tx_int, r[2]);
      check($sformatf("R4 row%0d tx_empty_int", i), tx_empty_int, r[1]);
      check($sformatf("R3 row%0d tx_ena", i), tx_ena, r[0]);
      check($sformatf("R2 row%0d cf_empty", i), cf_empty, !r[3]);
      if (r[3]) begin
        check($sformatf("R2 row%0d cf_head", i), cf_head, r[10:5]);
        pop_one();
      end
      if (!r[12]) check($sformatf("R3 row%0d fail_pnum", i), fail_pnum, r[10:5]);
      @(negedge clk);
      check($sformatf("R1 row%0d rel pulse ends", i), rel_req, 0);
    end

    // R6: tx_go tracks enable and queue state
    enable_tx();
    queue_empty = 1'b0;
    #1 check("R6 tx_go enabled", tx_go, 1);
    queue_empty = 1'b1;
    #1 check("R6 tx_go queue empty", tx_go, 0);

    // R7: fatal and set in same cycle -> clear wins; then restart
    @(negedge clk);
    auto_rel_en = 1'b1; tx_ok = 1'b0; tx_pnum = 6'd12; tx_done = 1'b1; tx_en_set = 1'b1;
    @(negedge clk);
    tx_done = 1'b0; tx_en_set = 1'b0;
    check("R7 clear wins", tx_ena, 0);
    check("R3 fail_pnum 12", fail_pnum, 12);
    pop_one();
    enable_tx();
    check("R7 restart", tx_ena, 1);

    // R9: set wins over clear, then clear
    @(negedge clk);
    auto_rel_en = 1'b0; tx_ok = 1'b1; queue_empty = 1'b1; tx_pnum = 6'd13;
    tx_done = 1'b1; int_ack = 2'b11;
    @(negedge clk);
    tx_done = 1'b0; int_ack = 2'b00;
    check("R9 tx_int set wins", tx_int, 1);
    check("R9 tx_empty_int set wins", tx_empty_int, 1);
    int_ack = 2'b01;
    @(negedge clk);
    int_ack = 2'b00;
    check("R9 tx_int cleared", tx_int, 0);
    check("R9 tx_empty_int kept", tx_empty_int, 1);
    pop_one();

    // R8: five writes into a 4-deep FIFO
    check("R8 start empty", cf_empty, 1);
    queue_empty = 1'b0; auto_rel_en = 1'b0; tx_ok = 1'b1;
    for (int k = 0; k < 5; k++) begin
      tx_pnum = PW'(20 + k); tx_done = 1'b1;
      @(negedge clk);
    end
    tx_done = 1'b0;
    check("R8 overflow set", cf_ovf, 1);
    for (int k = 0; k < 4; k++) begin
      check($sformatf("R8 order %0d", k), cf_head, 20 + k);
      pop_one();
    end
    check("R8 drained", cf_empty, 1);
    check("R8 overflow sticky", cf_ovf, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule